// File: doc/BRIEF.md
# Output Fault Protection Sequencer

This block decides, for each bridge output of a power stage, whether the output may switch. Each channel gets three comparator flags as inputs:
- a flag for a leakage path above the high current threshold, about 30 mA to ground or supply;
- a flag for leakage below the safe threshold;
- a flag for load current above the programmed short-circuit limit.

From these flags each channel drives four outputs: a tri-state command that turns the output stage off, a mute command, a request to the soft unmute ramp, and a sticky over-current status bit that the register block reads.

Every channel runs its own sequence. After enable, a channel stays tri-stated while its output leaks. When the leakage is safe it waits a fixed number of slow ticks, about 200 ms at a 1 kHz tick. It then drives its output muted and starts the unmute ramp. It plays once the ramp reports completion. An over-current during operation sends the channel back to tri-state, and it must pass the same leakage check before it recovers. A short across the two bridge terminals leaves the leakage flags clear, so the channel goes through the timed wait, mute and soft unmute. A fault on one channel never affects another.

Top module: `fault_seq_top`

## Requirements
- R1: While reset is high and right after it, every channel has tri_cmd=1, mute_cmd=1, ramp_req=0 and oc_status=0.
- R2: An enabled channel leaves the off state for the leak check one cycle after enable. While leak_hi=1 or leak_safe=0, the channel stays in the check with tri_cmd=1 and mute_cmd=1.
- R3: With leak_hi=0 and leak_safe=1, a checking channel enters the wait. On the cycle that carries the WAIT_TICKS-th tick_en pulse of the wait, it moves to muted drive: tri_cmd=0, mute_cmd=1, ramp_req=0.
- R4: If leak_safe drops or leak_hi rises during the wait, the channel returns to the check, and the tick count restarts from zero.
- R5: One cycle after muted drive, the channel asserts ramp_req=1 with mute_cmd=0 and tri_cmd=0. It holds this for as long as ramp_done=0.
- R6: ramp_done=1 while ramping moves the channel to play: tri_cmd, mute_cmd and ramp_req all 0. In play, tick_en has no effect.
- R7: oc_det=1 in any state other than off puts the channel back to off (tri_cmd=1, mute_cmd=1) on the next cycle. Recovery then passes through the check and a full wait again.
- R8: oc_status goes to 1 one cycle after any cycle with oc_det=1, and it stays 1. oc_clr=1 clears it only on a cycle where oc_det=0. When both are high, the set wins.
- R9: Channels are independent: inputs and faults of one channel leave the outputs of every other channel unchanged.
- R10: ch_en=0 puts the channel into off on the next cycle from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Slow timing enable pulse (nominally 1 kHz) |
| ch_en | input | NUM_CH | Per-channel enable |
| leak_hi | input | NUM_CH | Output leakage above the high threshold |
| leak_safe | input | NUM_CH | Output leakage below the safe threshold |
| oc_det | input | NUM_CH | Load current above the short-circuit limit |
| ramp_done | input | NUM_CH | Soft unmute ramp has completed |
| oc_clr | input | NUM_CH | Clear request for the over-current status bit |
| tri_cmd | output | NUM_CH | Output stage off (tri-state) |
| mute_cmd | output | NUM_CH | Mute command |
| ramp_req | output | NUM_CH | Soft unmute ramp request |
| oc_status | output | NUM_CH | Sticky over-current status |

## Verification
The bench builds the block with NUM_CH=2 and WAIT_TICKS=4. This makes a whole wait a handful of cycles instead of 200 tick periods. The exact tick that ends the wait can then be checked, and so can the restart of the count after a brief unsafe interval. The bench also runs a second wait after an over-current. Two channels let the bench fault one channel while the other sits in play, and then disable the playing channel while the faulted one recovers.

// File: rtl/fps_pkg.sv
`timescale 1ns/1ps
package fps_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_CHECK  = 3'd1,
        ST_WAIT   = 3'd2,
        ST_MUTED  = 3'd3,
        ST_UNMUTE = 3'd4,
        ST_PLAY   = 3'd5
    } fps_state_e;

    typedef struct packed {
        logic drv_off;
        logic mute;
        logic ramp;
    } fps_cmd_t;

    // Map a sequencer state onto the commands for the output stage.
    function automatic fps_cmd_t fps_decode(input fps_state_e st);
        fps_cmd_t c;
        case (st)
            ST_MUTED:  c = '{drv_off: 1'b0, mute: 1'b1, ramp: 1'b0};
            ST_UNMUTE: c = '{drv_off: 1'b0, mute: 1'b0, ramp: 1'b1};
            ST_PLAY:   c = '{drv_off: 1'b0, mute: 1'b0, ramp: 1'b0};
            default:   c = '{drv_off: 1'b1, mute: 1'b1, ramp: 1'b0};
        endcase
        return c;
    endfunction

    function automatic int unsigned fps_cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/fps_wait_timer.sv
`timescale 1ns/1ps
module fps_wait_timer #(
    parameter int unsigned WAIT_TICKS = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic done
);
    import fps_pkg::*;

    localparam int unsigned CW = fps_cnt_width(WAIT_TICKS);
    localparam logic [CW-1:0] LAST = CW'(WAIT_TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign done = run && tick && (cnt == LAST);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST) else $error("tick count beyond window"); // R3

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0) else $error("count not restarted"); // R4

endmodule

// File: rtl/fps_oc_latch.sv
`timescale 1ns/1ps
module fps_oc_latch (
    input  logic clk,
    input  logic rst,
    input  logic oc_in,
    input  logic clr,
    output logic status
);
    always_ff @(posedge clk) begin
        if (rst)
            status <= 1'b0;
        else if (oc_in)
            status <= 1'b1;
        else if (clr)
            status <= 1'b0;
    end

    AST_OC_SETS: assert property (@(posedge clk) disable iff (rst)
        oc_in |=> status) else $error("over-current not latched"); // R8

    AST_OC_STICKY: assert property (@(posedge clk) disable iff (rst)
        status && !clr |=> status) else $error("status lost without clear"); // R8

endmodule

// File: rtl/fps_chan_fsm.sv
`timescale 1ns/1ps
module fps_chan_fsm #(
    parameter int unsigned WAIT_TICKS = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic en,
    input  logic leak_hi,
    input  logic leak_safe,
    input  logic oc,
    input  logic ramp_done,
    output fps_pkg::fps_cmd_t cmd
);
    import fps_pkg::*;

    fps_state_e st, st_nx;
    logic       wait_done;
    logic       path_ok;

    assign path_ok = leak_safe && !leak_hi;

    fps_wait_timer #(.WAIT_TICKS(WAIT_TICKS)) u_timer (
        .clk (clk),
        .rst (rst),
        .run (st == ST_WAIT),
        .tick(tick),
        .done(wait_done)
    );

    always_comb begin
        st_nx = st;
        if (!en) begin
            st_nx = ST_OFF;
        end else if (oc && st != ST_OFF) begin
            st_nx = ST_OFF;
        end else begin
            case (st)
                ST_OFF:    st_nx = ST_CHECK;
                ST_CHECK:  if (path_ok) st_nx = ST_WAIT;
                ST_WAIT: begin
                    if (!path_ok)       st_nx = ST_CHECK;
                    else if (wait_done) st_nx = ST_MUTED;
                end
                ST_MUTED:  st_nx = ST_UNMUTE;
                ST_UNMUTE: if (ramp_done) st_nx = ST_PLAY;
                ST_PLAY:   st_nx = ST_PLAY;
                default:   st_nx = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_OFF;
        else     st <= st_nx;
    end

    assign cmd = fps_decode(st);

    AST_OC_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
        oc && st != ST_OFF |=> st == ST_OFF) else $error("over-current ignored"); // R7

    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> st == ST_OFF) else $error("disabled channel active"); // R10

    AST_MUTE_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
        st == ST_MUTED |-> $past(st) == ST_WAIT) else $error("muted without wait"); // R3

    AST_PLAY_VIA_RAMP: assert property (@(posedge clk) disable iff (rst)
        st == ST_PLAY && $past(st) != ST_PLAY |-> $past(st) == ST_UNMUTE) else $error("play without ramp"); // R6

    AST_RAMP_FOLLOWS_MUTE: assert property (@(posedge clk) disable iff (rst)
        st == ST_MUTED && en && !oc |=> st == ST_UNMUTE) else $error("no auto unmute"); // R5

endmodule

// File: rtl/fault_seq_top.sv
`timescale 1ns/1ps
module fault_seq_top #(
    parameter int unsigned NUM_CH     = 2,
    parameter int unsigned WAIT_TICKS = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] leak_hi,
    input  logic [NUM_CH-1:0] leak_safe,
    input  logic [NUM_CH-1:0] oc_det,
    input  logic [NUM_CH-1:0] ramp_done,
    input  logic [NUM_CH-1:0] oc_clr,
    output logic [NUM_CH-1:0] tri_cmd,
    output logic [NUM_CH-1:0] mute_cmd,
    output logic [NUM_CH-1:0] ramp_req,
    output logic [NUM_CH-1:0] oc_status
);
    import fps_pkg::*;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        fps_cmd_t cmd;

        fps_chan_fsm #(.WAIT_TICKS(WAIT_TICKS)) u_fsm (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick_en),
            .en       (ch_en[g]),
            .leak_hi  (leak_hi[g]),
            .leak_safe(leak_safe[g]),
            .oc       (oc_det[g]),
            .ramp_done(ramp_done[g]),
            .cmd      (cmd)
        );

        fps_oc_latch u_latch (
            .clk   (clk),
            .rst   (rst),
            .oc_in (oc_det[g]),
            .clr   (oc_clr[g]),
            .status(oc_status[g])
        );

        assign tri_cmd[g]  = cmd.drv_off;
        assign mute_cmd[g] = cmd.mute;
        assign ramp_req[g] = cmd.ramp;

        AST_RAMP_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (rst)
            ramp_req[g] |-> !tri_cmd[g] && !mute_cmd[g]) else $error("ramp while off"); // R5
    end

endmodule

// File: tb/sim_fault_seq_top.sv
`timescale 1ns/1ps
module sim_fault_seq_top;

    localparam int NCH = 2;
    localparam int WT  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b0;
    logic [NCH-1:0] ch_en = '0, leak_hi = '0, leak_safe = '0;
    logic [NCH-1:0] oc_det = '0, ramp_done = '0, oc_clr = '0;
    logic [NCH-1:0] tri_cmd, mute_cmd, ramp_req, oc_status;

    always #2 clk = ~clk;

    fault_seq_top #(.NUM_CH(NCH), .WAIT_TICKS(WT)) u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .ch_en(ch_en),
        .leak_hi(leak_hi), .leak_safe(leak_safe), .oc_det(oc_det),
        .ramp_done(ramp_done), .oc_clr(oc_clr),
        .tri_cmd(tri_cmd), .mute_cmd(mute_cmd), .ramp_req(ramp_req),
        .oc_status(oc_status)
    );

    typedef struct {
        int       ch;
        logic [3:0] v;   // {tri, mute, ramp, oc_status}
        string    tag;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Monitor: pops expectations and compares them with the outputs.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            logic [3:0] act;
            e = sb.pop_front();
            act = {tri_cmd[e.ch], mute_cmd[e.ch], ramp_req[e.ch], oc_status[e.ch]};
            checks++;
            if (act !== e.v) begin
                fails++;
                $display("FAIL %s ch%0d actual=%b expected=%b (tri,mute,ramp,oc)",
                         e.tag, e.ch, act, e.v);
            end
        end
    end

    task automatic drive(input logic [1:0] en, input logic [1:0] hi,
                         input logic [1:0] safe, input logic [1:0] oc,
                         input logic tk, input logic [1:0] rd,
                         input logic [1:0] clr);
        @(negedge clk);
        ch_en = en; leak_hi = hi; leak_safe = safe; oc_det = oc;
        tick_en = tk; ramp_done = rd; oc_clr = clr;
        @(posedge clk);
        #1;
    endtask

    task automatic push(input int ch, input logic [3:0] v, input string tag);
        exp_t e;
        e.ch = ch; e.v = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic push2(input logic [3:0] v0, input logic [3:0] v1, input string tag);
        push(0, v0, tag);
        push(1, v1, tag);
    endtask

    initial begin
        // R1: reset state
        drive(2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 2'b00, 2'b00);
        push2(4'b1100, 4'b1100, "R1");
        rst = 1'b0;
        // R2: leaking outputs stay off
        drive(2'b11, 2'b11, 2'b00, 2'b00, 1'b0, 2'b00, 2'b00);
        push2(4'b1100, 4'b1100, "R2");
        drive(2'b11, 2'b11, 2'b00, 2'b00, 1'b0, 2'b00, 2'b00);
        push2(4'b1100, 4'b1100, "R2");
        drive(2'b11, 2'b00, 2'b00, 2'b00, 1'b0, 2'b00, 2'b00);
        push2(4'b1100, 4'b1100, "R2");
        // R3: safe, wait starts
        drive(2'b11, 2'b00, 2'b11, 2'b00, 1'b0, 2'b00, 2'b00);
        push2(4'b1100, 4'b1100, "R3");
        for (int i = 0; i < WT - 1; i++) begin
            drive(2'b11, 2'b00, 2'b11, 2'b00, 1'b1, 2'b00, 2'b00);
            push2(4'b1100, 4'b1100, "R3");
        end
        // R4: unsafe blip restarts the count
        drive(2'b11, 2'b00, 2'b00, 2'b00, 1'b0, 2'b00, 2'b00);
        push2(4'b1100, 4'b1100, "R4");
        drive(2'b11, 2'b00, 2'b11, 2'b00, 1'b0, 2'b00, 2'b00);
        push2(4'b1100, 4'b1100, "R4");
        for (int i = 0; i < WT - 1; i++) begin
            drive(2'b11, 2'b00, 2'b11, 2'b00, 1'b1, 2'b00, 2'b00);
            push2(4'b1100, 4'b1100, "R4");
        end
        drive(2'b11, 2'b00, 2'b11, 2'b00, 1'b1, 2'b00, 2'b00);
        push2(4'b0100, 4'b0100, "R3");
        // R5: automatic ramp request
        drive(2'b11, 2'b00, 2'b11, 2'b00, 1'b0, 2'b00, 2'b00);
        push2(4'b0010, 4'b0010, "R5");
        drive(2'b11, 2'b00, 2'b11, 2'b00, 1'b1, 2'b00, 2'b00);
        push2(4'b0010, 4'b0010, "R5");
        // R6: ramp done -> play
        drive(2'b11, 2'b00, 2'b11, 2'b00, 1'b0, 2'b11, 2'b00);
        push2(4'b0000, 4'b0000, "R6");
        // R7/R8/R9: over-current on channel 0 only
        drive(2'b11, 2'b00, 2'b11, 2'b01, 1'b0, 2'b00, 2'b00);
        push2(4'b1101, 4'b0000, "R7_R8_R9");
        drive(2'b11, 2'b00, 2'b11, 2'b00, 1'b0, 2'b00, 2'b00);
        push2(4'b1101, 4'b0000, "R7");
        drive(2'b11, 2'b00, 2'b11, 2'b00, 1'b0, 2'b00, 2'b00);
        push2(4'b1101, 4'b0000, "R7");
        for (int i = 0; i < WT - 1; i++) begin
            drive(2'b11, 2'b00, 2'b11, 2'b00, 1'b1, 2'b00, 2'b00);
            push2(4'b1101, 4'b0000, "R7_R6");
        end
        drive(2'b11, 2'b00, 2'b11, 2'b00, 1'b1, 2'b00, 2'b00);
        push2(4'b0101, 4'b0000, "R7");
        // R8: clear, then set wins over clear during ramp
        drive(2'b11, 2'b00, 2'b11, 2'b00, 1'b0, 2'b00, 2'b01);
        push2(4'b0010, 4'b0000, "R8");
        drive(2'b11, 2'b00, 2'b11, 2'b01, 1'b0, 2'b00, 2'b01);
        push2(4'b1101, 4'b0000, "R8_R7");
        // R10: disable channel 1 from play
        drive(2'b01, 2'b00, 2'b11, 2'b00, 1'b0, 2'b00, 2'b00);
        push2(4'b1101, 4'b1100, "R10");
        drive(2'b11, 2'b00, 2'b11, 2'b00, 1'b0, 2'b00, 2'b00);
        push2(4'b1101, 4'b1100, "R10_R9");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #20000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule